// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM from power-up to normal operation. A one-cycle start pulse, accepted only while the block is idle, begins a fixed series of memory commands. Each command goes out on a small command port made of an opcode, a register-select field, an address word and a valid/ready handshake. A controller downstream turns each accepted command into pin activity. Partway through the series the sequencer holds off all traffic for a start-up wait. The length of that wait is a cycle count derived from the clock frequency.

At start the block captures the memory geometry. This is the column and row size codes, the address-mapping mode and the data-bus width. From these it computes the bit position where the register-select value is placed on the address word. When the last command has been accepted, the block raises a done flag and loads the refresh-rate value into an output register. The flag stays up until the next start.

Top module: `ddr2_powerup_seq`

## Requirements
- R1: After reset, `cmd_valid`, `busy`, `done` and `refresh_out` are all 0, and no command is offered until a start pulse arrives.
- R2: A start pulse while idle produces exactly fifteen accepted commands, in this order. Opcodes are 0=NOP, 1=precharge-all, 2=mode set (MRS), 3=extended mode set (EMRS), 4=auto-refresh, 5=normal mode, 6=dummy write. The order is NOP, NOP, precharge-all, EMRS, EMRS, EMRS, MRS, precharge-all, auto-refresh, auto-refresh, MRS, EMRS, EMRS, normal mode, dummy write.
- R3: After the first NOP is accepted, `cmd_valid` stays low for at least CLK_FREQ_MHZ*WAIT_US cycles and at most one cycle more. Only then is the second NOP offered.
- R4: `cmd_bank_sel` carries the extended register number for each EMRS, in the order 2, 3, 1, 1, 1. It is 0 for every MRS and for every other command.
- R5: `cmd_addr` equals `cmd_bank_sel` shifted left by the bank offset, with all other bits 0.
- R6: In sequential mapping (`cfg_interleave`=0), the bank offset is `cfg_col_code`+9+`cfg_row_code`+11+w. Here w=1 when `cfg_bus16`=1 (16-bit bus) and w=2 when it is 0 (32-bit bus).
- R7: In interleaved mapping (`cfg_interleave`=1), the row term is left out, so the bank offset is `cfg_col_code`+9+w.
- R8: `cmd_dll_rst` is 1 on the first MRS, the precharge-all after it and both auto-refreshes. It is 0 on every other command, including the second MRS.
- R9: `cmd_ocd_dflt` is 1 only on the fourth EMRS (OCD default) and 0 on the fifth EMRS (OCD exit) and on every other command.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, the offered command and all its fields hold unchanged in the next cycle. The sequence advances only on a cycle where both are 1.
- R11: A start pulse while `busy` is 1 is ignored. Configuration inputs that change during a run do not alter that run's commands.
- R12: One cycle after the dummy write is accepted, `done`=1, `busy`=0 and `refresh_out` equals `refresh_in`. `done` stays 1 with no command offered until the next start pulse, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin the sequence |
| cfg_col_code | input | 2 | Column size code |
| cfg_row_code | input | 2 | Row size code |
| cfg_interleave | input | 1 | 1 = interleaved bank mapping, 0 = sequential |
| cfg_bus16 | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| refresh_in | input | RFSH_W | Refresh-rate value to load at completion |
| cmd_ready | input | 1 | Downstream accepts the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd_code | output | 3 | Command opcode |
| cmd_bank_sel | output | 2 | Mode register number |
| cmd_addr | output | ADDR_W | Register number placed at the bank offset |
| cmd_dll_rst | output | 1 | DLL-reset bit for this command |
| cmd_ocd_dflt | output | 1 | OCD-default bits for this command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |
| refresh_out | output | RFSH_W | Loaded refresh-rate value |

## Verification
A wrong step index shows up at the command port as a wrong opcode, register number or DLL/OCD flag. It appears on the very next accepted command. A wrong bank offset, or configuration that is not captured at start, shows as a misplaced register number on `cmd_addr` at the first EMRS, about 2+CLK_FREQ_MHZ*WAIT_US cycles after start. A broken wait counter changes the gap before the second NOP. A lost handshake shows as changed fields while ready is low, or as a command count other than fifteen.

// File: rtl/ddr2_seq_pkg.sv
// Shared types for the DDR2 power-up sequencer: the command opcodes, the
// step record, and the fixed step table. The table is written as a
// function so that the step decode stays combinational.
package ddr2_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_PALL   = 3'd1,
        CMD_MRS    = 3'd2,
        CMD_EMRS   = 3'd3,
        CMD_REF    = 3'd4,
        CMD_NORMAL = 3'd5,
        CMD_WRITE  = 3'd6
    } cmd_e;

    localparam int STEP_W = 4;
    localparam int OFF_W  = 5;
    localparam logic [STEP_W-1:0] STEP_WAIT = 4'd1;
    localparam logic [STEP_W-1:0] STEP_LAST = 4'd15;

    typedef struct packed {
        cmd_e       code;
        logic [1:0] bank;
        logic       dll_rst;
        logic       ocd_dflt;
        logic       is_wait;
    } step_t;

    // Maps a step index to the command it offers.
    function automatic step_t step_decode(input logic [STEP_W-1:0] idx);
        step_t s;
        s = '{code: CMD_NOP, bank: 2'd0, dll_rst: 1'b0, ocd_dflt: 1'b0, is_wait: 1'b0};
        case (idx)
            4'd0:  s.code = CMD_NOP;
            4'd1:  s.is_wait = 1'b1;
            4'd2:  s.code = CMD_NOP;
            4'd3:  s.code = CMD_PALL;
            4'd4:  begin s.code = CMD_EMRS; s.bank = 2'd2; end
            4'd5:  begin s.code = CMD_EMRS; s.bank = 2'd3; end
            4'd6:  begin s.code = CMD_EMRS; s.bank = 2'd1; end
            4'd7:  begin s.code = CMD_MRS;  s.dll_rst = 1'b1; end
            4'd8:  begin s.code = CMD_PALL; s.dll_rst = 1'b1; end
            4'd9:  begin s.code = CMD_REF;  s.dll_rst = 1'b1; end
            4'd10: begin s.code = CMD_REF;  s.dll_rst = 1'b1; end
            4'd11: s.code = CMD_MRS;
            4'd12: begin s.code = CMD_EMRS; s.bank = 2'd1; s.ocd_dflt = 1'b1; end
            4'd13: begin s.code = CMD_EMRS; s.bank = 2'd1; end
            4'd14: s.code = CMD_NORMAL;
            default: s.code = CMD_WRITE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr2_bank_offset.sv
// Bank-offset calculator. It computes the address bit position where the
// mode register number is placed, from the geometry and the mapping mode.
// Assumes the inputs come from registers that are stable for a whole run.
module ddr2_bank_offset
    import ddr2_seq_pkg::*;
(
    input  logic [1:0]       col_code,
    input  logic [1:0]       row_code,
    input  logic             interleave,
    input  logic             bus16,
    output logic [OFF_W-1:0] offset
);
    localparam logic [OFF_W-1:0] COL_BASE = OFF_W'(9);
    localparam logic [OFF_W-1:0] ROW_BASE = OFF_W'(11);

    logic [OFF_W-1:0] row_term;
    logic [OFF_W-1:0] width_term;

    // Sums the column, row and bus-width terms; the row term is dropped when interleaved.
    always_comb begin
        row_term   = interleave ? '0 : (OFF_W'(row_code) + ROW_BASE);
        width_term = bus16 ? OFF_W'(1) : OFF_W'(2);
        offset     = OFF_W'(col_code) + COL_BASE + row_term + width_term;
    end
endmodule

// File: rtl/ddr2_wait_timer.sv
// Start-up wait counter. A load pulse sets it to LOAD_VAL, and it then
// counts down to zero. Assumes LOAD_VAL is at least 1.
module ddr2_wait_timer #(
    parameter int LOAD_VAL = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic running
);
    localparam int CNT_W = $clog2(LOAD_VAL + 1);

    logic [CNT_W-1:0] cnt;

    // Loads the count on request, otherwise counts down to zero and stays there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(LOAD_VAL);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign running = (cnt != '0);
endmodule

// File: rtl/ddr2_cmd_decode.sv
// Command decoder. It turns the current step into the fields offered on the
// command port, and places the register number at the bank offset.
// Assumes the offset is below ADDR_W-1.
module ddr2_cmd_decode
    import ddr2_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [STEP_W-1:0] step,
    input  logic              active,
    input  logic [OFF_W-1:0]  offset,
    output logic              valid,
    output logic              is_wait,
    output logic [2:0]        code,
    output logic [1:0]        bank,
    output logic [ADDR_W-1:0] addr,
    output logic              dll_rst,
    output logic              ocd_dflt
);
    step_t cur;

    // Decodes the step and masks every field while nothing is offered.
    always_comb begin
        cur      = step_decode(step);
        is_wait  = active && cur.is_wait;
        valid    = active && !cur.is_wait;
        code     = valid ? cur.code : CMD_NOP;
        bank     = valid ? cur.bank : 2'd0;
        dll_rst  = valid && cur.dll_rst;
        ocd_dflt = valid && cur.ocd_dflt;
        addr     = ADDR_W'(bank) << offset;
    end
endmodule

// File: rtl/ddr2_powerup_seq.sv
// DDR2 power-up sequencer top. A start pulse while idle captures the
// configuration and walks the fixed step table. Each command advances
// on a valid/ready handshake; the wait step advances when the timer expires.
// Assumes cmd_ready comes from a synchronous downstream controller.
module ddr2_powerup_seq
    import ddr2_seq_pkg::*;
#(
    parameter int CLK_FREQ_MHZ = 50,
    parameter int WAIT_US      = 200,
    parameter int ADDR_W       = 32,
    parameter int RFSH_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_col_code,
    input  logic [1:0]        cfg_row_code,
    input  logic              cfg_interleave,
    input  logic              cfg_bus16,
    input  logic [RFSH_W-1:0] refresh_in,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [1:0]        cmd_bank_sel,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_dll_rst,
    output logic              cmd_ocd_dflt,
    output logic              busy,
    output logic              done,
    output logic [RFSH_W-1:0] refresh_out
);
    localparam int WAIT_CYCLES = CLK_FREQ_MHZ * WAIT_US;

    logic              run_q;
    logic              done_q;
    logic [STEP_W-1:0] step_q;
    logic [1:0]        col_q;
    logic [1:0]        row_q;
    logic              il_q;
    logic              b16_q;
    logic [RFSH_W-1:0] rfsh_q;
    logic [OFF_W-1:0]  bank_off;
    logic              in_wait;
    logic              tmr_busy;
    logic              tmr_load;
    logic              accept;

    ddr2_bank_offset u_off (
        .col_code   (col_q),
        .row_code   (row_q),
        .interleave (il_q),
        .bus16      (b16_q),
        .offset     (bank_off)
    );

    ddr2_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .step     (step_q),
        .active   (run_q),
        .offset   (bank_off),
        .valid    (cmd_valid),
        .is_wait  (in_wait),
        .code     (cmd_code),
        .bank     (cmd_bank_sel),
        .addr     (cmd_addr),
        .dll_rst  (cmd_dll_rst),
        .ocd_dflt (cmd_ocd_dflt)
    );

    assign accept   = cmd_valid && cmd_ready;
    assign tmr_load = accept && (step_q == STEP_WAIT - 1'b1);

    ddr2_wait_timer #(.LOAD_VAL(WAIT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .running (tmr_busy)
    );

    // Sequencer: idle/start capture, wait-step exit, handshake advance and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            step_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            il_q   <= 1'b0;
            b16_q  <= 1'b0;
            rfsh_q <= '0;
        end else if (!run_q) begin
            if (start) begin
                run_q  <= 1'b1;
                done_q <= 1'b0;
                step_q <= '0;
                col_q  <= cfg_col_code;
                row_q  <= cfg_row_code;
                il_q   <= cfg_interleave;
                b16_q  <= cfg_bus16;
            end
        end else if (in_wait) begin
            if (!tmr_busy)
                step_q <= step_q + 1'b1;
        end else if (accept) begin
            if (step_q == STEP_LAST) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
                rfsh_q <= refresh_in;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign busy        = run_q;
    assign done        = done_q;
    assign refresh_out = rfsh_q;

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_bank_sel)
            && $stable(cmd_addr) && $stable(cmd_dll_rst) && $stable(cmd_ocd_dflt)));

    // R3
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !cmd_valid);

    // R4
    emrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_EMRS) |-> (cmd_bank_sel != 2'd0));

    // R4
    mrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_MRS) |-> (cmd_bank_sel == 2'd0));

    // R6
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bank_off >= OFF_W'(10) && bank_off <= OFF_W'(28)));

    // R8
    dll_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dll_rst |-> (cmd_code == CMD_MRS || cmd_code == CMD_PALL || cmd_code == CMD_REF));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !accept) |=> busy);

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_valid));
endmodule

// File: tb/sim_ddr2_powerup_seq.sv
module sim_ddr2_powerup_seq;
    localparam int MHZ    = 2;
    localparam int WUS    = 200;
    localparam int NWAIT  = MHZ * WUS;
    localparam int ADDR_W = 32;
    localparam int RFSH_W = 12;

    // expected commands: {code[2:0], bank[1:0], dll, ocd}
    localparam logic [6:0] EXP [15] = '{
        {3'd0, 2'd0, 1'b0, 1'b0}, {3'd0, 2'd0, 1'b0, 1'b0}, {3'd1, 2'd0, 1'b0, 1'b0},
        {3'd3, 2'd2, 1'b0, 1'b0}, {3'd3, 2'd3, 1'b0, 1'b0}, {3'd3, 2'd1, 1'b0, 1'b0},
        {3'd2, 2'd0, 1'b1, 1'b0}, {3'd1, 2'd0, 1'b1, 1'b0}, {3'd4, 2'd0, 1'b1, 1'b0},
        {3'd4, 2'd0, 1'b1, 1'b0}, {3'd2, 2'd0, 1'b0, 1'b0}, {3'd3, 2'd1, 1'b0, 1'b1},
        {3'd3, 2'd1, 1'b0, 1'b0}, {3'd5, 2'd0, 1'b0, 1'b0}, {3'd6, 2'd0, 1'b0, 1'b0}
    };

    // geometry vectors: {col[1:0], row[1:0], interleave, bus16, expected offset[4:0]}
    localparam logic [10:0] GEO [8] = '{
        {2'd0, 2'd0, 1'b0, 1'b1, 5'd21}, {2'd3, 2'd3, 1'b0, 1'b0, 5'd28},
        {2'd1, 2'd2, 1'b0, 1'b0, 5'd25}, {2'd2, 2'd1, 1'b0, 1'b1, 5'd24},
        {2'd0, 2'd3, 1'b1, 1'b1, 5'd10}, {2'd3, 2'd0, 1'b1, 1'b0, 5'd14},
        {2'd2, 2'd3, 1'b1, 1'b0, 5'd13}, {2'd1, 2'd1, 1'b1, 1'b1, 5'd11}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        cfg_col_code = '0;
    logic [1:0]        cfg_row_code = '0;
    logic              cfg_interleave = 1'b0;
    logic              cfg_bus16 = 1'b0;
    logic [RFSH_W-1:0] refresh_in = '0;
    logic              cmd_ready = 1'b0;
    logic              cmd_valid;
    logic [2:0]        cmd_code;
    logic [1:0]        cmd_bank_sel;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_dll_rst;
    logic              cmd_ocd_dflt;
    logic              busy;
    logic              done;
    logic [RFSH_W-1:0] refresh_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ddr2_powerup_seq #(.CLK_FREQ_MHZ(MHZ), .WAIT_US(WUS), .ADDR_W(ADDR_W), .RFSH_W(RFSH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_col_code(cfg_col_code), .cfg_row_code(cfg_row_code),
        .cfg_interleave(cfg_interleave), .cfg_bus16(cfg_bus16),
        .refresh_in(refresh_in), .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank_sel(cmd_bank_sel),
        .cmd_addr(cmd_addr), .cmd_dll_rst(cmd_dll_rst), .cmd_ocd_dflt(cmd_ocd_dflt),
        .busy(busy), .done(done), .refresh_out(refresh_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one full sequence with a ready-delay pattern; optional mid-run start and cfg change.
    task automatic run_seq(input logic [1:0] col, input logic [1:0] row, input logic il,
                           input logic b16, input int exp_off, input int mode, input bit poke);
        int idx, hold, gap, cyc;
        bit pv;
        logic [6:0] got, pf;
        logic [ADDR_W-1:0] pa, ea;
        idx = 0; hold = 0; gap = 0; cyc = 0; pv = 1'b0; pf = '0; pa = '0;
        cfg_col_code = col; cfg_row_code = row; cfg_interleave = il; cfg_bus16 = b16;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2", "busy after start", {busy, done}, 2'b10);
        while (idx < 15 && cyc < 5000) begin
            got = {cmd_code, cmd_bank_sel, cmd_dll_rst, cmd_ocd_dflt};
            if (pv) check(cmd_valid && got == pf && cmd_addr == pa, "R10", "held command", got, pf);
            // R11: start pulse and cfg change during the run
            start = (poke && idx == 6 && hold == 0);
            if (poke && idx == 6) begin
                cfg_col_code = ~col; cfg_row_code = ~row; cfg_interleave = ~il; cfg_bus16 = ~b16;
            end
            if (cmd_valid) begin
                if (hold >= (idx + mode) % 3) begin
                    ea = ADDR_W'(EXP[idx][3:2]) << exp_off;
                    check(got[6:4] == EXP[idx][6:4], "R2", $sformatf("code step %0d", idx), got[6:4], EXP[idx][6:4]);
                    check(got[3:2] == EXP[idx][3:2], "R4", $sformatf("bank step %0d", idx), got[3:2], EXP[idx][3:2]);
                    check(got[1] == EXP[idx][1], "R8", $sformatf("dll step %0d", idx), got[1], EXP[idx][1]);
                    check(got[0] == EXP[idx][0], "R9", $sformatf("ocd step %0d", idx), got[0], EXP[idx][0]);
                    check(cmd_addr == ea, il ? "R7" : "R6", $sformatf("addr step %0d (R5)", idx), cmd_addr, ea);
                    if (idx == 1)
                        check(gap >= NWAIT && gap <= NWAIT + 1, "R3", "wait gap", gap, NWAIT);
                    cmd_ready = 1'b1; pv = 1'b0; idx++; hold = 0;
                end else begin
                    cmd_ready = 1'b0; pv = 1'b1; pf = got; pa = cmd_addr; hold++;
                end
            end else begin
                cmd_ready = 1'b0; pv = 1'b0;
                if (idx == 1) gap++;
            end
            cyc++;
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        start = 1'b0;
        check(idx == 15, "R2", "command count", idx, 15);
        check(done && !busy && !cmd_valid, "R12", "done flag", {done, busy, cmd_valid}, 3'b100);
        check(refresh_out == refresh_in, "R12", "refresh load", refresh_out, refresh_in);
    endtask

    initial begin
        #3800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with start and ready asserted during reset
        start = 1'b1; cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!cmd_valid && !busy && !done && refresh_out == '0, "R1", "in reset",
              {cmd_valid, busy, done}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!cmd_valid && !busy && !done && refresh_out == '0, "R1", "idle without start",
              {cmd_valid, busy, done}, 0);
        cmd_ready = 1'b0;

        // geometry table walk
        for (int i = 0; i < 8; i++) begin
            refresh_in = RFSH_W'(12'h100 + i);
            run_seq(GEO[i][10:9], GEO[i][8:7], GEO[i][6], GEO[i][5], int'(GEO[i][4:0]), i % 3, 1'b0);
        end

        // every geometry and mode combination, offset from R6/R7 formula
        for (int c = 0; c < 64; c++) begin
            int off;
            off = (c & 3) + 9 + (((c >> 4) & 1) ? 0 : ((c >> 2) & 3) + 11) + (((c >> 5) & 1) ? 1 : 2);
            refresh_in = RFSH_W'(12'h200 + c);
            run_seq(2'(c), 2'(c >> 2), c[4], c[5], off, c % 3, 1'b0);
        end

        // R11: start and cfg change mid-run are ignored
        refresh_in = 12'hABC;
        run_seq(2'd1, 2'd2, 1'b0, 1'b1, 1 + 9 + 2 + 11 + 1, 0, 1'b1);

        // R12: done persists while idle, then a new start clears it
        repeat (5) @(negedge clk);
        check(done && !cmd_valid && !busy, "R12", "done persists", {done, cmd_valid, busy}, 3'b100);
        refresh_in = 12'h555;
        check(refresh_out == 12'hABC, "R12", "refresh held", refresh_out, 12'hABC);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && busy, "R12", "start clears done", {done, busy}, 2'b01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule